// File: doc/BRIEF.md
# I2C Target Interface with Host-Controlled Clock Stretching

This block is the target (slave) side of an I2C bus with a 7-bit address. It oversamples the open-drain SCL and SDA lines with the system clock and finds start and stop conditions. It shifts in the address byte and compares it with the configured address. In the write direction it receives bytes into a single data buffer. In the read direction it sends bytes that the host places in that buffer. The host sees a small register-style view: the buffer, a buffer-full flag, an overflow flag, a direction flag and a per-byte interrupt flag. It controls the block with single-cycle pulses that read the buffer, write transmit data, clear flags and release a stretched clock.

The block stretches SCL by holding it low until the host issues a release pulse. In the write direction it stretches only when stretch mode is enabled. In the read direction it always stretches, so that the host has time to supply the next byte. If the host has not consumed a received byte before the next one arrives, the new byte is refused with a NACK.

Top module: `i2c_target_stretch`

## Requirements
- R1: After reset, `scl_oe`, `sda_oe`, `buf_full`, `ovf`, `dir_read`, `irq` and `buf_data` are all zero.
- R2: An address byte whose upper seven bits equal `own_addr` and whose bit 0 is 0 is acknowledged: SDA is pulled low for the ninth clock. `dir_read` becomes 0, `buf_data` holds the whole address byte and `buf_full` becomes 1.
- R3: An address byte that does not match is not acknowledged and does not raise `irq`. The block then drives neither line and ignores every following byte until the next start condition.
- R4: In the write direction, each accepted data byte is acknowledged, loaded into `buf_data` MSB-first as received, and sets `buf_full`. A `host_rd_buf` pulse clears `buf_full`.
- R5: A write-direction byte that completes while `buf_full` or `ovf` is 1 is NACKed and leaves `buf_data` unchanged. If `buf_full` was 1, `ovf` is set. Only a `host_clr_ovf` pulse clears `ovf`.
- R6: `irq` is set once for every acknowledged or overflow-refused byte, including the address byte. It stays at 1 until a `host_clr_irq` pulse.
- R7: In the write direction, SCL is held low after the ninth clock of each byte only when `stretch_en` is 1. It stays held until a `host_release` pulse. With `stretch_en` at 0, SCL is never held.
- R8: A matching address byte with bit 0 equal to 1 is acknowledged, sets `dir_read` to 1, loads the address byte into `buf_data` and sets `buf_full`. SCL is then held low whatever the value of `stretch_en`, until a `host_release` pulse.
- R9: A `host_wr_buf` pulse loads `host_wdata` into the buffer and the transmit shift register. The eight bits go out MSB first. SDA changes only while SCL is low.
- R10: On the ninth clock of a read byte, the controller's SDA is sampled at the SCL rising edge. If it is low (ACK), `irq` is set at the following falling edge and SCL is held again. If it is high (NACK), `dir_read` is cleared, `irq` is not raised, SCL is not held and the block waits for a start condition.
- R11: A start condition (SDA falling while SCL is high) at any point restarts address reception. A stop condition (SDA rising while SCL is high) returns the block to idle, where bytes clocked without a new start get no acknowledge.
- R12: A `host_rd_buf` pulse in the same cycle as a received byte is loaded counts as consuming the old byte. The new byte is acknowledged and loaded, `buf_full` stays 1 and `ovf` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst | input | 1 | Synchronous active-high reset |
| own_addr | input | 7 | Address this target answers to |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_oe | output | 1 | 1 pulls SCL low (stretch) |
| sda_oe | output | 1 | 1 pulls SDA low (ACK or data 0) |
| stretch_en | input | 1 | Enables stretching after received write bytes |
| host_release | input | 1 | Pulse: release a stretched SCL |
| host_wr_buf | input | 1 | Pulse: write `host_wdata` to buffer and transmit register |
| host_wdata | input | 8 | Transmit data from the host |
| host_rd_buf | input | 1 | Pulse: host consumes the buffer |
| host_clr_irq | input | 1 | Pulse: clear `irq` |
| host_clr_ovf | input | 1 | Pulse: clear `ovf` |
| buf_data | output | 8 | Data buffer contents |
| buf_full | output | 1 | Buffer holds an unconsumed byte |
| ovf | output | 1 | A byte arrived while the buffer was full |
| dir_read | output | 1 | 1 when the current transfer is controller-read |
| irq | output | 1 | Per-byte interrupt flag |

## Verification
Two actions can land on the same clock edge: a host read that empties the buffer, and the byte-load decision taken at the falling edge of the eighth SCL clock. The bench sets up a full buffer by leaving the address byte unread. It then counts the line delay through the synchronizer and edge detector and places a one-cycle `host_rd_buf` pulse exactly on the edge where the next byte is decided. The result is judged at the ports. The byte must be acknowledged and stored, `buf_full` must still read 1 and `ovf` must still read 0, where a design that let the read lose would report an overflow and a NACK.

// File: rtl/i2ct_pkg.sv
`timescale 1ns/1ps
package i2ct_pkg;

    localparam int ADDR_W = 7;
    localparam int BYTE_W = 8;
    localparam int CNT_W  = $clog2(BYTE_W + 2);

    typedef logic [BYTE_W-1:0] byte_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_RX,
        ST_TX,
        ST_SKIP
    } tgt_state_e;

    typedef struct packed {
        logic full;
        logic ovf;
        logic rd_dir;
        logic irq;
    } tgt_flags_t;

    function automatic logic addr_hit(input byte_t b, input logic [ADDR_W-1:0] a);
        return b[BYTE_W-1:1] == a;
    endfunction

endpackage

// File: rtl/i2ct_line_sync.sv
`timescale 1ns/1ps
module i2ct_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);

    logic [STAGES-1:0] ff;

    // Idle bus level is high, so the chain resets to ones.
    always_ff @(posedge clk) begin
        if (rst) ff <= '1;
        else     ff <= {ff[STAGES-2:0], din};
    end

    assign dout = ff[STAGES-1];

endmodule

// File: rtl/i2ct_bus_cond.sv
`timescale 1ns/1ps
module i2ct_bus_cond (
    input  logic clk,
    input  logic rst,
    input  logic scl_s,
    input  logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic bus_start,
    output logic bus_stop
);

    logic scl_q, sda_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_s;
            sda_q <= sda_s;
        end
    end

    assign scl_rise  = scl_s & ~scl_q;
    assign scl_fall  = ~scl_s & scl_q;
    assign bus_start = scl_s & scl_q & sda_q & ~sda_s;
    assign bus_stop  = scl_s & scl_q & ~sda_q & sda_s;

endmodule

// File: rtl/i2c_target_stretch.sv
`timescale 1ns/1ps
module i2c_target_stretch
    import i2ct_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              scl_oe,
    output logic              sda_oe,
    input  logic              stretch_en,
    input  logic              host_release,
    input  logic              host_wr_buf,
    input  logic [BYTE_W-1:0] host_wdata,
    input  logic              host_rd_buf,
    input  logic              host_clr_irq,
    input  logic              host_clr_ovf,
    output logic [BYTE_W-1:0] buf_data,
    output logic              buf_full,
    output logic              ovf,
    output logic              dir_read,
    output logic              irq
);

    localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W);
    localparam logic [CNT_W-1:0] ACK_BIT  = CNT_W'(BYTE_W + 1);

    // ---------------- line conditioning ----------------
    logic [1:0] raw_lines, sync_lines;
    logic       scl_s, sda_s;
    logic       scl_rise, scl_fall, bus_start, bus_stop;

    assign raw_lines = {sda_i, scl_i};

    for (genvar g = 0; g < 2; g++) begin : g_sync
        i2ct_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk  (clk),
            .rst  (rst),
            .din  (raw_lines[g]),
            .dout (sync_lines[g])
        );
    end

    assign scl_s = sync_lines[0];
    assign sda_s = sync_lines[1];

    i2ct_bus_cond u_cond (
        .clk       (clk),
        .rst       (rst),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .bus_start (bus_start),
        .bus_stop  (bus_stop)
    );

    // ---------------- transfer engine ----------------
    tgt_state_e       state;
    logic [CNT_W-1:0] cnt;        // SCL rising edges seen in this byte
    byte_t            rx_sh, tx_sh, buf_q;
    logic             tx_en, ack_drv, hold;
    tgt_flags_t       flags;
    logic             rx_blocked;

    // A host read in the same cycle frees the buffer for the arriving byte.
    assign rx_blocked = (flags.full & ~host_rd_buf) | flags.ovf;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            cnt     <= '0;
            rx_sh   <= '0;
            tx_sh   <= '0;
            buf_q   <= '0;
            tx_en   <= 1'b0;
            ack_drv <= 1'b0;
            hold    <= 1'b0;
            flags   <= '0;
        end else begin
            // Host side first; bus events below take precedence.
            if (host_rd_buf)  flags.full <= 1'b0;
            if (host_clr_irq) flags.irq  <= 1'b0;
            if (host_clr_ovf) flags.ovf  <= 1'b0;
            if (host_release) hold       <= 1'b0;
            if (host_wr_buf) begin
                buf_q <= host_wdata;
                tx_sh <= host_wdata;
            end

            if (bus_start) begin
                state   <= ST_ADDR;
                cnt     <= '0;
                ack_drv <= 1'b0;
                tx_en   <= 1'b0;
                hold    <= 1'b0;
            end else if (bus_stop) begin
                state   <= ST_IDLE;
                ack_drv <= 1'b0;
                tx_en   <= 1'b0;
                hold    <= 1'b0;
            end else begin
                case (state)
                    ST_ADDR, ST_RX: begin
                        if (scl_rise) begin
                            if (cnt < LAST_BIT) rx_sh <= {rx_sh[BYTE_W-2:0], sda_s};
                            if (cnt < ACK_BIT)  cnt   <= cnt + CNT_ONE;
                        end
                        if (scl_fall && cnt == LAST_BIT) begin
                            if (state == ST_ADDR && !addr_hit(rx_sh, own_addr)) begin
                                state <= ST_SKIP;
                            end else if (state == ST_ADDR && rx_sh[0]) begin
                                buf_q        <= rx_sh;
                                flags.full   <= 1'b1;
                                flags.rd_dir <= 1'b1;
                                ack_drv      <= 1'b1;
                            end else begin
                                if (state == ST_ADDR) flags.rd_dir <= 1'b0;
                                if (rx_blocked) begin
                                    if (flags.full && !host_rd_buf) flags.ovf <= 1'b1;
                                end else begin
                                    buf_q      <= rx_sh;
                                    flags.full <= 1'b1;
                                    ack_drv    <= 1'b1;
                                end
                            end
                        end
                        if (scl_fall && cnt == ACK_BIT) begin
                            ack_drv   <= 1'b0;
                            flags.irq <= 1'b1;
                            cnt       <= '0;
                            if (flags.rd_dir) begin
                                state <= ST_TX;
                                hold  <= 1'b1;
                                tx_en <= 1'b1;
                            end else begin
                                state <= ST_RX;
                                hold  <= stretch_en;
                            end
                        end
                    end
                    ST_TX: begin
                        if (scl_rise && cnt < ACK_BIT) begin
                            cnt <= cnt + CNT_ONE;
                            if (cnt == LAST_BIT && sda_s) begin
                                // Controller NACK: transfer over.
                                state        <= ST_IDLE;
                                flags.rd_dir <= 1'b0;
                                cnt          <= '0;
                            end
                        end
                        if (scl_fall) begin
                            if (cnt >= CNT_ONE && cnt < LAST_BIT)
                                tx_sh <= {tx_sh[BYTE_W-2:0], 1'b1};
                            if (cnt == LAST_BIT) tx_en <= 1'b0;
                            if (cnt == ACK_BIT) begin
                                cnt       <= '0;
                                flags.irq <= 1'b1;
                                hold      <= 1'b1;
                                tx_en     <= 1'b1;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign scl_oe   = hold;
    assign sda_oe   = ack_drv | (tx_en & ~tx_sh[BYTE_W-1]);
    assign buf_data = buf_q;
    assign buf_full = flags.full;
    assign ovf      = flags.ovf;
    assign dir_read = flags.rd_dir;
    assign irq      = flags.irq;

    // ---------------- assertions ----------------
    assert_skip_silent_R3: assert property (@(posedge clk) disable iff (rst)
        (state == ST_SKIP) |-> (!sda_oe && !scl_oe));

    assert_ovf_sticky_R5: assert property (@(posedge clk) disable iff (rst)
        (ovf && !host_clr_ovf) |=> ovf);

    assert_irq_sticky_R6: assert property (@(posedge clk) disable iff (rst)
        (irq && !host_clr_irq) |=> irq);

    assert_hold_until_release_R7: assert property (@(posedge clk) disable iff (rst)
        (scl_oe && !host_release && !bus_start && !bus_stop) |=> scl_oe);

    assert_sda_moves_low_R9: assert property (@(posedge clk) disable iff (rst)
        (!$stable(sda_oe)) |-> (!$past(scl_s) || $past(bus_start) ||
                                $past(bus_stop) || $past(host_wr_buf)));

endmodule

// File: tb/tb_i2c_target_stretch.sv
`timescale 1ns/1ps
module tb_i2c_target_stretch;

    localparam int          H   = 12;
    localparam logic [6:0]  OWN = 7'h3A;

    // {addr7, data8, stretch, expect_ack}
    localparam logic [16:0] VEC [0:5] = '{
        {7'h3A, 8'hA5, 1'b0, 1'b1},
        {7'h3A, 8'h00, 1'b1, 1'b1},
        {7'h15, 8'h5A, 1'b0, 1'b0},
        {7'h3A, 8'hFF, 1'b1, 1'b1},
        {7'h3B, 8'h33, 1'b1, 1'b0},
        {7'h3A, 8'h80, 1'b0, 1'b1}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ctl_scl = 1'b1, ctl_sda = 1'b1;
    logic scl_line, sda_line;
    logic scl_oe, sda_oe;
    logic stretch_en = 1'b0;
    logic host_release = 1'b0, host_wr_buf = 1'b0, host_rd_buf = 1'b0;
    logic host_clr_irq = 1'b0, host_clr_ovf = 1'b0;
    logic [7:0] host_wdata = 8'h00;
    logic [7:0] buf_data;
    logic buf_full, ovf, dir_read, irq;
    logic [6:0] own_addr = OWN;

    int n_chk = 0, n_fail = 0;
    bit sda_glitch = 1'b0;

    always #2.5 clk = ~clk;

    assign scl_line = ctl_scl & ~scl_oe;
    assign sda_line = ctl_sda & ~sda_oe;

    i2c_target_stretch dut (
        .clk(clk), .rst(rst), .own_addr(own_addr),
        .scl_i(scl_line), .sda_i(sda_line),
        .scl_oe(scl_oe), .sda_oe(sda_oe),
        .stretch_en(stretch_en), .host_release(host_release),
        .host_wr_buf(host_wr_buf), .host_wdata(host_wdata),
        .host_rd_buf(host_rd_buf), .host_clr_irq(host_clr_irq),
        .host_clr_ovf(host_clr_ovf), .buf_data(buf_data),
        .buf_full(buf_full), .ovf(ovf), .dir_read(dir_read), .irq(irq)
    );

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic hold_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse(ref logic sig);
        @(negedge clk) sig = 1'b1;
        @(negedge clk) sig = 1'b0;
    endtask

    task automatic host_write(input logic [7:0] d);
        @(negedge clk) begin host_wr_buf = 1'b1; host_wdata = d; end
        @(negedge clk) host_wr_buf = 1'b0;
    endtask

    task automatic wait_scl_high();
        while (scl_line !== 1'b1) @(negedge clk);
    endtask

    // One SCL clock; coinc places a host read on the edge that acts on this fall.
    task automatic clock_bit(input logic b, input bit coinc, output logic r);
        logic r_early;
        ctl_sda = b;
        hold_n(H);
        ctl_scl = 1'b1;
        wait_scl_high();
        @(negedge clk) r_early = sda_line;
        hold_n(H);
        r = sda_line;
        if (r_early !== r) sda_glitch = 1'b1;
        ctl_scl = 1'b0;
        if (coinc) begin
            @(negedge clk);
            @(negedge clk) host_rd_buf = 1'b1;
            @(negedge clk) host_rd_buf = 1'b0;
            @(negedge clk);
        end else begin
            hold_n(4);
        end
    endtask

    task automatic send_byte(input logic [7:0] b, input bit coinc, output bit ack);
        logic r;
        for (int i = 7; i >= 0; i--) clock_bit(b[i], coinc && (i == 0), r);
        clock_bit(1'b1, 1'b0, r);
        ack = (r == 1'b0);
    endtask

    task automatic recv_byte(input logic nack, output logic [7:0] d);
        logic r;
        d = 8'h00;
        for (int i = 0; i < 8; i++) begin
            clock_bit(1'b1, 1'b0, r);
            d = {d[6:0], r};
        end
        clock_bit(nack, 1'b0, r);
    endtask

    task automatic bus_start();
        ctl_sda = 1'b1;
        hold_n(4);
        ctl_scl = 1'b1;
        wait_scl_high();
        hold_n(H);
        ctl_sda = 1'b0;
        hold_n(H);
        ctl_scl = 1'b0;
        hold_n(4);
    endtask

    task automatic bus_stop();
        ctl_sda = 1'b0;
        hold_n(H);
        ctl_scl = 1'b1;
        wait_scl_high();
        hold_n(H);
        ctl_sda = 1'b1;
        hold_n(H);
    endtask

    task automatic tidy();
        pulse(host_rd_buf);
        pulse(host_clr_irq);
        pulse(host_clr_ovf);
    endtask

    task automatic run_vectors();
        for (int i = 0; i < 6; i++) begin
            logic [16:0] v;
            logic [7:0]  ab, db;
            bit          ack, exp_ack, st;
            v       = VEC[i];
            ab      = {v[16:10], 1'b0};
            db      = v[9:2];
            st      = v[1];
            exp_ack = v[0];
            stretch_en = st;
            bus_start();
            send_byte(ab, 1'b0, ack);
            hold_n(4);
            if (exp_ack) begin
                chk("R2 address ack", ack, 1);
                chk("R2 dir_read", dir_read, 0);
                chk("R2 buffer holds address", buf_data, ab);
                chk("R2 buf_full", buf_full, 1);
                chk("R6 irq on address", irq, 1);
                hold_n(20);
                chk("R7 stretch after address", scl_oe, st);
                pulse(host_rd_buf);
                chk("R4 read clears buf_full", buf_full, 0);
                pulse(host_clr_irq);
                chk("R6 irq cleared by host", irq, 0);
                if (st) begin
                    pulse(host_release);
                    chk("R7 release frees SCL", scl_oe, 0);
                end
                send_byte(db, 1'b0, ack);
                hold_n(4);
                chk("R4 data ack", ack, 1);
                chk("R4 data in buffer", buf_data, db);
                chk("R4 buf_full", buf_full, 1);
                chk("R6 irq on data", irq, 1);
                hold_n(20);
                chk("R7 stretch after data", scl_oe, st);
                tidy();
                if (st) pulse(host_release);
            end else begin
                chk("R3 no ack on mismatch", ack, 0);
                chk("R3 no irq on mismatch", irq, 0);
                send_byte(db, 1'b0, ack);
                hold_n(4);
                chk("R3 later byte ignored", ack, 0);
                chk("R3 no irq after mismatch", irq, 0);
                chk("R3 SCL never held", scl_oe, 0);
            end
            bus_stop();
        end
        stretch_en = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual hung expected completion");
        summary();
        $finish;
    end

    initial begin
        bit         ack;
        logic [7:0] d;
        logic       r;

        hold_n(5);
        rst = 1'b0;
        hold_n(2);
        // R1 reset state
        chk("R1 scl_oe", scl_oe, 0);
        chk("R1 sda_oe", sda_oe, 0);
        chk("R1 buf_full", buf_full, 0);
        chk("R1 ovf", ovf, 0);
        chk("R1 dir_read", dir_read, 0);
        chk("R1 irq", irq, 0);
        chk("R1 buf_data", buf_data, 0);

        run_vectors();

        // R5 overflow
        bus_start();
        send_byte({OWN, 1'b0}, 1'b0, ack);
        pulse(host_clr_irq);
        send_byte(8'h11, 1'b0, ack);
        hold_n(4);
        chk("R5 NACK on full", ack, 0);
        chk("R5 ovf set", ovf, 1);
        chk("R5 buffer unchanged", buf_data, {OWN, 1'b0});
        chk("R6 irq on refused byte", irq, 1);
        hold_n(50);
        chk("R6 irq stays set", irq, 1);
        pulse(host_rd_buf);
        pulse(host_clr_irq);
        send_byte(8'h22, 1'b0, ack);
        hold_n(4);
        chk("R5 NACK while ovf", ack, 0);
        chk("R5 buffer still unchanged", buf_data, {OWN, 1'b0});
        chk("R5 ovf survives read", ovf, 1);
        pulse(host_clr_ovf);
        chk("R5 host clears ovf", ovf, 0);
        send_byte(8'h33, 1'b0, ack);
        hold_n(4);
        chk("R5 accepted after clear", ack, 1);
        chk("R5 buffer loaded after clear", buf_data, 8'h33);
        bus_stop();
        tidy();

        // R8/R9/R10 read direction, stretch disabled
        stretch_en = 1'b0;
        bus_start();
        send_byte({OWN, 1'b1}, 1'b0, ack);
        hold_n(4);
        chk("R8 read address ack", ack, 1);
        chk("R8 dir_read", dir_read, 1);
        chk("R8 buffer holds address", buf_data, {OWN, 1'b1});
        chk("R8 buf_full", buf_full, 1);
        hold_n(40);
        chk("R8 SCL held without stretch_en", scl_oe, 1);
        chk("R8 line low while held", scl_line, 0);
        tidy();
        host_write(8'hC3);
        sda_glitch = 1'b0;
        pulse(host_release);
        recv_byte(1'b0, d);
        hold_n(4);
        chk("R9 first byte MSB first", d, 8'hC3);
        chk("R9 SDA steady while SCL high", sda_glitch, 0);
        chk("R10 irq after controller ACK", irq, 1);
        chk("R10 SCL held again", scl_oe, 1);
        pulse(host_clr_irq);
        host_write(8'h5A);
        pulse(host_release);
        recv_byte(1'b1, d);
        hold_n(4);
        chk("R9 second byte", d, 8'h5A);
        chk("R10 dir_read cleared on NACK", dir_read, 0);
        chk("R10 no irq on NACK", irq, 0);
        chk("R10 no stretch on NACK", scl_oe, 0);
        bus_stop();
        tidy();

        // R11 repeated start aborts, stop returns to idle
        bus_start();
        send_byte({OWN, 1'b0}, 1'b0, ack);
        tidy();
        for (int i = 0; i < 3; i++) clock_bit(1'b1, 1'b0, r);
        bus_start();
        send_byte({OWN, 1'b0}, 1'b0, ack);
        hold_n(4);
        chk("R11 address after restart", ack, 1);
        tidy();
        send_byte(8'h6C, 1'b0, ack);
        hold_n(4);
        chk("R11 data after restart ack", ack, 1);
        chk("R11 data after restart", buf_data, 8'h6C);
        bus_stop();
        tidy();
        ctl_scl = 1'b0;
        hold_n(4);
        send_byte({OWN, 1'b0}, 1'b0, ack);
        hold_n(4);
        chk("R11 idle after stop: no ack", ack, 0);
        chk("R11 idle after stop: no irq", irq, 0);
        ctl_scl = 1'b1;
        hold_n(H);

        // R12 host read coinciding with byte load
        bus_start();
        send_byte({OWN, 1'b0}, 1'b0, ack);
        pulse(host_clr_irq);
        chk("R12 buffer full before", buf_full, 1);
        send_byte(8'h9E, 1'b1, ack);
        hold_n(4);
        chk("R12 byte acknowledged", ack, 1);
        chk("R12 byte loaded", buf_data, 8'h9E);
        chk("R12 buf_full kept", buf_full, 1);
        chk("R12 no overflow", ovf, 0);
        bus_stop();
        tidy();

        summary();
        $finish;
    end

endmodule